// File: doc/BRIEF.md
# Power-up reset delay sequencer

This block keeps a processor core in reset after a power-on or brown-out event until the supply and the clock can be trusted. It runs a chain of waiting phases in a fixed order: a power-on delay first, then an optional long power-up delay, then a count of raw oscillator edges when a crystal mode is selected, and finally a short lock delay when a PLL clock is selected. Only after the last of these phases does it release the core reset. The tick-based phases are measured in ticks of a free-running timebase. The oscillator phase counts rising edges of the raw oscillator clock, which is synchronised into the block clock domain.

External and watchdog resets skip the power-on and power-up phases and restart the chain at the oscillator phase. The block also gates the core clock: the clock is off during Sleep and off while the sequence is still running. Sleep ends on an interrupt, which enables the clock again without a reset, or on any reset event. A phase output lets the surrounding logic and the testbench follow the sequence.

Top module: `pwrup_rst_seq`

## Requirements
- R1: While `rst_n_i` is low, `phase_o` reads IDLE (0), `core_rst_o` is 1 and `clk_gate_en_o` is 0.
- R2: A `por_i` or `bor_i` pulse moves `phase_o` to POR (1) on the next clock edge. The phase lasts until POR_TICKS ticks of `tick_i` have been seen in it.
- R3: After POR the block enters PWRT (2) only if `pwrt_en_i` is 1. PWRT lasts PWRT_TICKS ticks. PWRT is never entered from any phase other than POR.
- R4: The OST phase (3) is used only in the crystal modes: `osc_mode_i` 0, 1 or 2. It lasts until OST_EDGES synchronised rising edges of `osc_clk_i` have been counted. Modes 3 to 7 skip the phase.
- R5: When `pll_en_i` is 1, a PLL phase (4) of PLL_TICKS ticks follows the preceding phases, and RUN (5) comes only after it.
- R6: `core_rst_o` is 1 in every cycle where `phase_o` is not RUN. It falls exactly one clock after `phase_o` first shows RUN.
- R7: A `por_i` or `bor_i` pulse in any phase restarts the sequence at POR with a fresh count.
- R8: While `ext_rst_i` is 1, `phase_o` is IDLE and `core_rst_o` is 1. Once it is released, the sequence starts at OST, or at PLL or RUN when those come first, and skips POR and PWRT.
- R9: A `wdt_rst_i` pulse restarts the sequence at the same entry point as R8, with no POR or PWRT phase.
- R10: A `sleep_i` pulse in RUN drops `clk_gate_en_o` and leaves `core_rst_o` at 0, until `wake_irq_i` or a reset event. In any phase other than RUN, `sleep_i` is ignored.
- R11: A reset event seen in RUN sets `core_rst_o` on the same clock edge on which `phase_o` leaves RUN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_n_i | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| tick_i | input | 1 | One-cycle timebase tick |
| osc_clk_i | input | 1 | Raw oscillator clock, sampled and synchronised |
| por_i | input | 1 | Power-on event pulse |
| bor_i | input | 1 | Brown-out event pulse |
| ext_rst_i | input | 1 | External reset, level |
| wdt_rst_i | input | 1 | Watchdog reset pulse |
| pwrt_en_i | input | 1 | Enables the long power-up phase |
| osc_mode_i | input | 3 | Oscillator mode, values 0 to 2 are crystal |
| pll_en_i | input | 1 | PLL clock selected |
| sleep_i | input | 1 | Sleep request pulse |
| wake_irq_i | input | 1 | Enabled interrupt, ends Sleep |
| core_rst_o | output | 1 | Registered core reset, active high |
| clk_gate_en_o | output | 1 | Core clock enable |
| phase_o | output | 3 | Current phase: IDLE 0, POR 1, PWRT 2, OST 3, PLL 4, RUN 5 |

## Verification
The hardest case to reach from the ports is a restart that lands in the middle of a long phase, after part of a count has built up. If the counter were not cleared, the leftover count would shorten the new phase. The stimulus waits until the block has spent several cycles in PWRT and then fires a brown-out pulse. A cycle-accurate reference model, together with a measured length for each phase, catches any phase that runs short. A second hard case is a watchdog reset in a non-crystal PLL mode, which must pass straight from RUN to the PLL phase with no OST in between.

// File: rtl/rds_pkg.sv
package rds_pkg;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_POR  = 3'd1,
    PH_PWRT = 3'd2,
    PH_OST  = 3'd3,
    PH_PLL  = 3'd4,
    PH_RUN  = 3'd5
  } phase_e;

  // crystal modes are the three lowest encodings
  function automatic logic osc_is_xtal(input logic [2:0] mode);
    return mode < 3'd3;
  endfunction

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/rds_osc_edge.sv
module rds_osc_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic osc_i,
  output logic rise_o
);
  localparam int DEPTH = SYNC_STAGES + 1;

  logic [DEPTH-1:0] shf_q, shf_d;

  always_comb begin
    shf_d = shf_q;
    for (int i = DEPTH - 1; i > 0; i--) shf_d[i] = shf_q[i-1];
    shf_d[0] = osc_i;
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) shf_q <= '0;
    else          shf_q <= shf_d;
  end

  assign rise_o = shf_q[SYNC_STAGES-1] & ~shf_q[SYNC_STAGES];

  // R4: a rise lasts exactly one cycle
  assert_rise_single_R4: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    rise_o |=> !rise_o);

endmodule

// File: rtl/rds_span_ctr.sv
module rds_span_ctr #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_n_i,
  input  logic         clr_i,
  input  logic         step_i,
  input  logic [W-1:0] last_i,
  output logic         hit_o
);
  logic [W-1:0] cnt_q, cnt_d;

  assign hit_o = step_i & (cnt_q == last_i);

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)       cnt_d = '0;
    else if (hit_o)  cnt_d = '0;
    else if (step_i) cnt_d = cnt_q + W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) cnt_q <= '0;
    else          cnt_q <= cnt_d;
  end

  // R2 (and R4 for the edge counter): count never passes the phase limit
  assert_cnt_bound_R2: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    cnt_q <= last_i);

endmodule

// File: rtl/rds_seq_fsm.sv
module rds_seq_fsm
  import rds_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_n_i,
  input  logic   ext_rst_i,
  input  logic   pwr_evt_i,
  input  logic   wdt_rst_i,
  input  logic   pwrt_en_i,
  input  logic   xtal_i,
  input  logic   pll_en_i,
  input  logic   tick_hit_i,
  input  logic   edge_hit_i,
  output phase_e phase_o,
  output logic   cnt_clr_o
);
  phase_e phase_q, phase_d;
  phase_e after_pwrt, after_por;
  logic   ext_q;
  logic   restart;

  always_comb begin
    after_pwrt = xtal_i ? PH_OST : (pll_en_i ? PH_PLL : PH_RUN);
    after_por  = pwrt_en_i ? PH_PWRT : after_pwrt;
    phase_d    = phase_q;
    restart    = 1'b0;
    if (ext_rst_i) begin
      phase_d = PH_IDLE;
      restart = 1'b1;
    end else if (pwr_evt_i) begin
      phase_d = PH_POR;
      restart = 1'b1;
    end else if (wdt_rst_i) begin
      phase_d = after_pwrt;
      restart = 1'b1;
    end else begin
      unique case (phase_q)
        PH_IDLE: if (ext_q)      phase_d = after_pwrt;
        PH_POR:  if (tick_hit_i) phase_d = after_por;
        PH_PWRT: if (tick_hit_i) phase_d = after_pwrt;
        PH_OST:  if (edge_hit_i) phase_d = pll_en_i ? PH_PLL : PH_RUN;
        PH_PLL:  if (tick_hit_i) phase_d = PH_RUN;
        PH_RUN:  phase_d = PH_RUN;
        default: phase_d = PH_IDLE;
      endcase
    end
  end

  assign cnt_clr_o = restart | (phase_d != phase_q);
  assign phase_o   = phase_q;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      phase_q <= PH_IDLE;
      ext_q   <= 1'b0;
    end else begin
      phase_q <= phase_d;
      ext_q   <= ext_rst_i;
    end
  end

  assert_pwrt_after_por_R3: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (phase_q == PH_PWRT && $past(phase_q) != PH_PWRT) |-> $past(phase_q) == PH_POR);

  assert_ost_xtal_only_R4: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (phase_q == PH_OST && $past(phase_q) != PH_OST) |-> $past(xtal_i));

  assert_pll_not_skipped_R5: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (phase_q == PH_RUN && $past(phase_q) == PH_OST) |-> !$past(pll_en_i));

  assert_pwr_restart_R7: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (pwr_evt_i && !ext_rst_i) |=> phase_q == PH_POR);

  assert_ext_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    ext_rst_i |=> phase_q == PH_IDLE);

  assert_wdt_skip_R9: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (wdt_rst_i && !ext_rst_i && !pwr_evt_i) |=> (phase_q != PH_POR && phase_q != PH_PWRT));

endmodule

// File: rtl/pwrup_rst_seq.sv
module pwrup_rst_seq
  import rds_pkg::*;
#(
  parameter int POR_TICKS   = 4,
  parameter int PWRT_TICKS  = 72,
  parameter int PLL_TICKS   = 2,
  parameter int OST_EDGES   = 1024,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_n_i,
  input  logic       tick_i,
  input  logic       osc_clk_i,
  input  logic       por_i,
  input  logic       bor_i,
  input  logic       ext_rst_i,
  input  logic       wdt_rst_i,
  input  logic       pwrt_en_i,
  input  logic [2:0] osc_mode_i,
  input  logic       pll_en_i,
  input  logic       sleep_i,
  input  logic       wake_irq_i,
  output logic       core_rst_o,
  output logic       clk_gate_en_o,
  output logic [2:0] phase_o
);
  localparam int TMAX = max3(POR_TICKS, PWRT_TICKS, PLL_TICKS);
  localparam int TW   = $clog2(TMAX + 1);
  localparam int EW   = $clog2(OST_EDGES + 1);

  phase_e        phase_q;
  logic          cnt_clr, osc_rise;
  logic          tick_step, edge_step, tick_hit, edge_hit;
  logic [TW-1:0] tick_last;
  logic          any_evt;
  logic          core_rst_q, core_rst_d;
  logic          sleep_q, sleep_d;

  rds_osc_edge #(.SYNC_STAGES(SYNC_STAGES)) osc_edge_i (
    .clk_i (clk_i), .rst_n_i (rst_n_i), .osc_i (osc_clk_i), .rise_o (osc_rise)
  );

  always_comb begin
    unique case (phase_q)
      PH_POR:  tick_last = TW'(POR_TICKS - 1);
      PH_PWRT: tick_last = TW'(PWRT_TICKS - 1);
      PH_PLL:  tick_last = TW'(PLL_TICKS - 1);
      default: tick_last = '0;
    endcase
  end

  assign tick_step = tick_i & (phase_q == PH_POR || phase_q == PH_PWRT || phase_q == PH_PLL);
  assign edge_step = osc_rise & (phase_q == PH_OST);

  // one tick counter is shared by the POR, PWRT and PLL phases
  rds_span_ctr #(.W(TW)) tick_ctr_i (
    .clk_i (clk_i), .rst_n_i (rst_n_i), .clr_i (cnt_clr), .step_i (tick_step),
    .last_i (tick_last), .hit_o (tick_hit)
  );

  rds_span_ctr #(.W(EW)) edge_ctr_i (
    .clk_i (clk_i), .rst_n_i (rst_n_i), .clr_i (cnt_clr), .step_i (edge_step),
    .last_i (EW'(OST_EDGES - 1)), .hit_o (edge_hit)
  );

  rds_seq_fsm fsm_i (
    .clk_i      (clk_i),
    .rst_n_i    (rst_n_i),
    .ext_rst_i  (ext_rst_i),
    .pwr_evt_i  (por_i | bor_i),
    .wdt_rst_i  (wdt_rst_i),
    .pwrt_en_i  (pwrt_en_i),
    .xtal_i     (osc_is_xtal(osc_mode_i)),
    .pll_en_i   (pll_en_i),
    .tick_hit_i (tick_hit),
    .edge_hit_i (edge_hit),
    .phase_o    (phase_q),
    .cnt_clr_o  (cnt_clr)
  );

  assign any_evt = por_i | bor_i | ext_rst_i | wdt_rst_i;

  always_comb begin
    core_rst_d = (phase_q != PH_RUN) | any_evt;
    sleep_d    = sleep_q;
    if (any_evt || wake_irq_i)           sleep_d = 1'b0;
    else if (phase_q == PH_RUN && sleep_i) sleep_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      core_rst_q <= 1'b1;
      sleep_q    <= 1'b0;
    end else begin
      core_rst_q <= core_rst_d;
      sleep_q    <= sleep_d;
    end
  end

  assign core_rst_o    = core_rst_q;
  assign clk_gate_en_o = (phase_q == PH_RUN) & ~sleep_q;
  assign phase_o       = phase_q;

  assert_rst_outside_run_R6: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (phase_q != PH_RUN) |-> core_rst_q);

  assert_release_late_R6: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    $fell(core_rst_q) |-> ($past(phase_q) == PH_RUN && phase_q == PH_RUN));

  assert_sleep_in_run_R10: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    $rose(sleep_q) |-> $past(phase_q) == PH_RUN);

  assert_evt_sets_rst_R11: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    any_evt |=> core_rst_q);

endmodule

// File: tb/pwrup_rst_seq_tb_top.sv
`timescale 1ns/1ps
module pwrup_rst_seq_tb_top;
  localparam int P_POR = 3, P_PWRT = 5, P_PLL = 2, P_OST = 8;
  localparam int TICK_DIV = 4, OSC_HALF = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, osc = 1'b0;
  logic por = 0, bor = 0, ext = 0, wdt = 0, pwrt_en = 1, pll = 0, slp = 0, wake = 0;
  logic [2:0] mode = 3'd2;
  logic core_rst, gate;
  logic [2:0] phase;

  int total = 0, bad = 0, cyc = 0;
  string req = "R1";

  always #2 clk = ~clk;

  pwrup_rst_seq #(.POR_TICKS(P_POR), .PWRT_TICKS(P_PWRT), .PLL_TICKS(P_PLL),
                  .OST_EDGES(P_OST)) dut_i (
    .clk_i (clk), .rst_n_i (rst_n), .tick_i (tick), .osc_clk_i (osc),
    .por_i (por), .bor_i (bor), .ext_rst_i (ext), .wdt_rst_i (wdt),
    .pwrt_en_i (pwrt_en), .osc_mode_i (mode), .pll_en_i (pll),
    .sleep_i (slp), .wake_irq_i (wake),
    .core_rst_o (core_rst), .clk_gate_en_o (gate), .phase_o (phase)
  );

  // timebase and raw oscillator, both driven on the falling edge
  int tdiv = 0, odiv = 0;
  always @(negedge clk) begin
    tdiv = (tdiv + 1) % TICK_DIV;
    tick <= (tdiv == 0);
    odiv = (odiv + 1) % OSC_HALF;
    if (odiv == 0) osc <= ~osc;
  end

  // behavioural reference model
  int m_ph = 0, m_cnt = 0;
  bit m_o1, m_o2, m_o3, m_ext, m_rst = 1, m_slp;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = 0; m_cnt = 0; m_o1 = 0; m_o2 = 0; m_o3 = 0; m_ext = 0; m_rst = 1; m_slp = 0;
    end else begin
      bit e, evt, xt, hit, rs;
      int nph, nxt_pw, lim;
      e = m_o2 && !m_o3; m_o3 = m_o2; m_o2 = m_o1; m_o1 = osc;
      evt = por || bor || ext || wdt;
      xt = (mode <= 2);
      nxt_pw = xt ? 3 : (pll ? 4 : 5);
      lim = (m_ph == 1) ? P_POR : (m_ph == 2) ? P_PWRT : (m_ph == 4) ? P_PLL : P_OST;
      hit = (m_ph == 3) ? (e && m_cnt == lim - 1) :
            ((m_ph == 1 || m_ph == 2 || m_ph == 4) && tick && m_cnt == lim - 1);
      nph = m_ph; rs = 0;
      if (ext) begin nph = 0; rs = 1; end
      else if (por || bor) begin nph = 1; rs = 1; end
      else if (wdt) begin nph = nxt_pw; rs = 1; end
      else if (m_ph == 0 && m_ext) nph = nxt_pw;
      else if (hit) begin
        if (m_ph == 1) nph = pwrt_en ? 2 : nxt_pw;
        else if (m_ph == 2) nph = nxt_pw;
        else if (m_ph == 3) nph = pll ? 4 : 5;
        else nph = 5;
      end
      m_rst = (m_ph != 5) || evt;
      if (evt || wake) m_slp = 0; else if (m_ph == 5 && slp) m_slp = 1;
      if (rs || nph != m_ph) m_cnt = 0;
      else if ((m_ph == 3 && e) || (m_ph != 3 && m_ph != 0 && m_ph != 5 && tick)) m_cnt++;
      m_ph = nph; m_ext = ext;
    end
  end

  task automatic chk(input string r, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", r, what, act, exp);
    end
  endtask

  // per-cycle comparison and phase-length bookkeeping
  int run_len = 0, last_ph = 0;
  int dur[8];
  int trail[$];
  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      total++; bad++;
      $display("FAIL watchdog: actual=%0d expected=0", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
    chk(req, "phase", phase, m_ph);
    chk(req, "core_rst", core_rst, m_rst);
    chk(req, "clk_gate", gate, (m_ph == 5) && !m_slp);
    if (int'(phase) == last_ph) run_len++;
    else begin
      dur[last_ph] = run_len + 1; run_len = 0; last_ph = phase; trail.push_back(phase);
    end
  end

  task automatic wait_ph(input int p);
    for (int i = 0; i < 2000 && int'(phase) != p; i++) @(negedge clk);
  endtask
  task automatic idle_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    // R1: reset state
    idle_n(3);
    chk("R1", "reset phase", phase, 0);
    chk("R1", "reset core_rst", core_rst, 1);
    chk("R1", "reset gate", gate, 0);
    rst_n = 1; idle_n(2);

    // R2 R3 R4 R5 R6: full crystal + PLL sequence
    req = "R5"; mode = 3'd2; pll = 1; pwrt_en = 1;
    trail.delete();
    por = 1; @(negedge clk); por = 0;
    chk("R2", "entry", phase, 1);
    wait_ph(5);
    chk("R6", "still reset at RUN entry", core_rst, 1);
    @(negedge clk);
    chk("R6", "released one cycle later", core_rst, 0);
    chk("R3", "order len", trail.size(), 5);
    if (trail.size() == 5) begin
      chk("R3", "order0", trail[0], 1); chk("R3", "order1", trail[1], 2);
      chk("R4", "order2", trail[2], 3); chk("R5", "order3", trail[3], 4);
      chk("R5", "order4", trail[4], 5);
    end
    chk("R2", "POR length ok", (dur[1] > (P_POR-1)*TICK_DIV && dur[1] <= P_POR*TICK_DIV + 1), 1);
    chk("R3", "PWRT length ok", (dur[2] > (P_PWRT-1)*TICK_DIV && dur[2] <= P_PWRT*TICK_DIV), 1);
    chk("R4", "OST length ok", (dur[3] > (P_OST-1)*2*OSC_HALF && dur[3] <= P_OST*2*OSC_HALF), 1);
    chk("R5", "PLL length ok", (dur[4] > (P_PLL-1)*TICK_DIV && dur[4] <= P_PLL*TICK_DIV), 1);

    // R4 R3: non-crystal mode, no power-up timer, no PLL -> POR then RUN
    req = "R4"; mode = 3'd5; pll = 0; pwrt_en = 0;
    trail.delete();
    bor = 1; @(negedge clk); bor = 0;
    chk("R11", "reset on bor in RUN", core_rst, 1);
    wait_ph(5); idle_n(2);
    chk("R4", "skip trail len", trail.size(), 2);
    if (trail.size() == 2) chk("R4", "POR then RUN", trail[1], 5);

    // R7: restart in the middle of PWRT
    req = "R7"; mode = 3'd0; pwrt_en = 1;
    por = 1; @(negedge clk); por = 0;
    wait_ph(2); idle_n(7);
    bor = 1; @(negedge clk); bor = 0;
    chk("R7", "back to POR", phase, 1);
    wait_ph(2);
    chk("R7", "full PWRT again", phase, 2);
    idle_n(P_PWRT*TICK_DIV - 6);
    chk("R7", "PWRT not shortened", phase, 2);
    wait_ph(5); idle_n(2);

    // R8: external reset held then released
    req = "R8"; mode = 3'd1; pll = 0;
    ext = 1; idle_n(10);
    chk("R8", "held idle", phase, 0);
    chk("R8", "held reset", core_rst, 1);
    ext = 0; idle_n(2);
    chk("R8", "starts at OST", phase, 3);
    wait_ph(5); idle_n(2);

    // R9 R11: watchdog in non-crystal PLL mode
    req = "R9"; mode = 3'd3; pll = 1;
    wdt = 1; @(negedge clk); wdt = 0;
    chk("R9", "goes to PLL", phase, 4);
    chk("R11", "reset same edge", core_rst, 1);
    wait_ph(5); idle_n(2);

    // R10: sleep and wake
    req = "R10";
    slp = 1; @(negedge clk); slp = 0;
    chk("R10", "gate off", gate, 0);
    chk("R10", "no reset in sleep", core_rst, 0);
    idle_n(5);
    chk("R10", "still asleep", gate, 0);
    wake = 1; @(negedge clk); wake = 0;
    chk("R10", "gate back", gate, 1);
    // sleep outside RUN is ignored
    mode = 3'd4; pll = 0; pwrt_en = 0;
    por = 1; @(negedge clk); por = 0;
    slp = 1; @(negedge clk); slp = 0;
    wait_ph(5); idle_n(2);
    chk("R10", "ignored before RUN", gate, 1);

    idle_n(4);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule